// File: doc/BRIEF.md
# Global DSCP Priority Map

This block holds one shared translation table that turns the 6-bit differentiated-services code point of an IP packet into two priorities. The first is a 2-bit queue priority that picks the egress queue. The second is a 3-bit frame priority. Every port of the switch uses the same table. Each of the 64 code points always has a mapping. There is no invalid or empty entry. After reset, every entry holds a default that is computed from its own code point.

Software reaches the table through a single 16-bit register on a plain register bus. A write with the commit bit clear only moves the entry pointer, and a later read returns the entry at that pointer. A write with the commit bit set stores new priorities into the entry named in that same write. The same register also holds one global flag that tells the packet path to take its frame priority from the IP header.

The packet path has its own lookup port. A code point goes in, and the two priorities come out combinationally in the same cycle.

Top module: `dscp_prio_map`

## Requirements
- R1: After reset, entry d holds queue priority d>>4 and frame priority d>>3. The pointer is 0 and the global flag is 0. Every entry always yields a priority.
- R2: A write to the map address with bit 15 clear loads bits 13:8 into the pointer. It leaves every table entry and the global flag unchanged, whatever the other bits hold.
- R3: A read at the map address returns this layout:
  - bit 14 is the global flag;
  - bits 13:8 are the pointer;
  - bits 6:4 are the selected entry's frame priority;
  - bits 1:0 are the selected entry's queue priority;
  - bits 15, 7, 3 and 2 read as 0.
- R4: A write to the map address with bit 15 set stores bits 6:4 as frame priority and bits 1:0 as queue priority into entry bits 13:8. It also leaves the pointer at that index. Bits 7, 3 and 2 are ignored.
- R5: The global flag takes bit 14 only on writes with bit 15 set. It is driven on `use_ip_fpri`.
- R6: `lk_qpri` and `lk_fpri` show, in the same cycle, the entry selected by `lk_dscp`. During a commit write to that entry they still show the old value. From the next cycle on they show the new value.
- R7: Writes to any address other than the map address change no state. Reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register bus address |
| reg_wdata | input | 16 | Register bus write data |
| reg_we | input | 1 | Register bus write strobe |
| reg_rdata | output | 16 | Register bus read data (combinational) |
| lk_dscp | input | 6 | Code point from the packet path |
| lk_qpri | output | 2 | Mapped queue priority |
| lk_fpri | output | 3 | Mapped frame priority |
| use_ip_fpri | output | 1 | Global flag: take frame priority from the IP header |

## Verification
The packet-path lookup and a software commit write can land on the same entry in the same cycle.

The bench provokes this case directly. It drives a commit to one code point while `lk_dscp` names that same code point. It then samples the lookup outputs before the clock edge and again after it.

The check passes only if the old priorities appear in the write cycle and the new ones appear in the next cycle.

A companion property compares the lookup outputs with the register read-back whenever both select the same entry. It fires if the two read paths ever disagree.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
   // Bit positions of the indirect map register; the software view depends on them.
   localparam int REG_W     = 16;
   localparam int BIT_COMMIT = 15;
   localparam int BIT_FLAG   = 14;
   localparam int PTR_LSB    = 8;
   localparam int FPRI_LSB   = 4;
   localparam int QPRI_LSB   = 0;

   // Reset default: the top bits of the code point.
   function automatic int unsigned dflt_prio(int unsigned code, int unsigned code_w,
                                             int unsigned prio_w);
      return code >> (code_w - prio_w);
   endfunction
endpackage

// File: rtl/dpm_regif.sv
module dpm_regif
   import dpm_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int MAP_ADDR = 25,
   parameter int DSCP_W   = 6,
   parameter int QPRI_W   = 2,
   parameter int FPRI_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [REG_W-1:0]    reg_wdata,
   input  logic                reg_we,
   output logic [REG_W-1:0]    reg_rdata,
   input  logic [QPRI_W-1:0]   sel_qpri,
   input  logic [FPRI_W-1:0]   sel_fpri,
   output logic [DSCP_W-1:0]   ptr,
   output logic                flag,
   output logic                commit,
   output logic [DSCP_W-1:0]   commit_idx,
   output logic [QPRI_W-1:0]   commit_qpri,
   output logic [FPRI_W-1:0]   commit_fpri
);
   localparam logic [ADDR_W-1:0] MAP_A = ADDR_W'(MAP_ADDR);

   logic hit, wr_hit;

   assign hit    = (reg_addr == MAP_A);
   assign wr_hit = reg_we && hit;

   assign commit      = wr_hit && reg_wdata[BIT_COMMIT];
   assign commit_idx  = reg_wdata[PTR_LSB +: DSCP_W];
   assign commit_qpri = reg_wdata[QPRI_LSB +: QPRI_W];
   assign commit_fpri = reg_wdata[FPRI_LSB +: FPRI_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr  <= '0;
         flag <= 1'b0;
      end else begin
         if (wr_hit) ptr <= commit_idx;
         if (commit) flag <= reg_wdata[BIT_FLAG];
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit) begin
         reg_rdata[BIT_FLAG]              = flag;
         reg_rdata[PTR_LSB +: DSCP_W]     = ptr;
         reg_rdata[FPRI_LSB +: FPRI_W]    = sel_fpri;
         reg_rdata[QPRI_LSB +: QPRI_W]    = sel_qpri;
      end
   end
endmodule

// File: rtl/dpm_table.sv
module dpm_table
   import dpm_pkg::*;
#(
   parameter int DSCP_W = 6,
   parameter int QPRI_W = 2,
   parameter int FPRI_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DSCP_W-1:0] wr_idx,
   input  logic [QPRI_W-1:0] wr_qpri,
   input  logic [FPRI_W-1:0] wr_fpri,
   input  logic [DSCP_W-1:0] rd_idx,
   output logic [QPRI_W-1:0] rd_qpri,
   output logic [FPRI_W-1:0] rd_fpri,
   input  logic [DSCP_W-1:0] lk_idx,
   output logic [QPRI_W-1:0] lk_qpri,
   output logic [FPRI_W-1:0] lk_fpri
);
   localparam int DEPTH = 1 << DSCP_W;

   logic [QPRI_W-1:0] q_mem [DEPTH];
   logic [FPRI_W-1:0] f_mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      localparam logic [QPRI_W-1:0] Q_RST = QPRI_W'(dflt_prio(i, DSCP_W, QPRI_W));
      localparam logic [FPRI_W-1:0] F_RST = FPRI_W'(dflt_prio(i, DSCP_W, FPRI_W));
      logic sel;
      assign sel = wr_en && (wr_idx == DSCP_W'(i));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_mem[i] <= Q_RST;
            f_mem[i] <= F_RST;
         end else if (sel) begin
            q_mem[i] <= wr_qpri;
            f_mem[i] <= wr_fpri;
         end
      end
   end

   assign rd_qpri = q_mem[rd_idx];
   assign rd_fpri = f_mem[rd_idx];
   assign lk_qpri = q_mem[lk_idx];
   assign lk_fpri = f_mem[lk_idx];
endmodule

// File: rtl/dscp_prio_map.sv
module dscp_prio_map
   import dpm_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int MAP_ADDR = 25,
   parameter int DSCP_W   = 6,
   parameter int QPRI_W   = 2,
   parameter int FPRI_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [15:0]       reg_wdata,
   input  logic              reg_we,
   output logic [15:0]       reg_rdata,
   input  logic [DSCP_W-1:0] lk_dscp,
   output logic [QPRI_W-1:0] lk_qpri,
   output logic [FPRI_W-1:0] lk_fpri,
   output logic              use_ip_fpri
);
   // Field widths must fit the fixed register layout.
   if (DSCP_W < 1 || DSCP_W > 6) begin : g_bad_dscp
      $error("DSCP_W must be 1..6");
   end
   if (QPRI_W < 1 || QPRI_W > 2 || QPRI_W > DSCP_W) begin : g_bad_q
      $error("QPRI_W must be 1..2 and not above DSCP_W");
   end
   if (FPRI_W < 1 || FPRI_W > 3 || FPRI_W > DSCP_W) begin : g_bad_f
      $error("FPRI_W must be 1..3 and not above DSCP_W");
   end
   if (MAP_ADDR < 0 || MAP_ADDR >= (1 << ADDR_W)) begin : g_bad_a
      $error("MAP_ADDR out of address range");
   end

   logic [DSCP_W-1:0] ptr_q, c_idx;
   logic              flag_q, c_en;
   logic [QPRI_W-1:0] c_q, s_q;
   logic [FPRI_W-1:0] c_f, s_f;

   dpm_regif #(
      .ADDR_W(ADDR_W), .MAP_ADDR(MAP_ADDR),
      .DSCP_W(DSCP_W), .QPRI_W(QPRI_W), .FPRI_W(FPRI_W)
   ) u_regif (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .reg_rdata(reg_rdata),
      .sel_qpri(s_q), .sel_fpri(s_f),
      .ptr(ptr_q), .flag(flag_q),
      .commit(c_en), .commit_idx(c_idx), .commit_qpri(c_q), .commit_fpri(c_f)
   );

   dpm_table #(
      .DSCP_W(DSCP_W), .QPRI_W(QPRI_W), .FPRI_W(FPRI_W)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(c_en), .wr_idx(c_idx), .wr_qpri(c_q), .wr_fpri(c_f),
      .rd_idx(ptr_q), .rd_qpri(s_q), .rd_fpri(s_f),
      .lk_idx(lk_dscp), .lk_qpri(lk_qpri), .lk_fpri(lk_fpri)
   );

   assign use_ip_fpri = flag_q;
endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
   parameter int ADDR_W   = 5,
   parameter int MAP_ADDR = 25,
   parameter int DSCP_W   = 6,
   parameter int QPRI_W   = 2,
   parameter int FPRI_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [15:0]       reg_wdata,
   input logic              reg_we,
   input logic [15:0]       reg_rdata,
   input logic [DSCP_W-1:0] lk_dscp,
   input logic [QPRI_W-1:0] lk_qpri,
   input logic [FPRI_W-1:0] lk_fpri,
   input logic              use_ip_fpri,
   input logic [DSCP_W-1:0] ptr
);
   localparam logic [ADDR_W-1:0] MAP_A = ADDR_W'(MAP_ADDR);
   logic hit;
   assign hit = (reg_addr == MAP_A);

   p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && hit) |=> ptr == $past(reg_wdata[8 +: DSCP_W]));

   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && hit) |=> $stable(ptr));

   p_rd_layout_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (reg_rdata[15] == 1'b0 && reg_rdata[7] == 1'b0 && reg_rdata[3:2] == 2'b00
               && reg_rdata[14] == use_ip_fpri && reg_rdata[8 +: DSCP_W] == ptr));

   p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> reg_rdata == 16'h0000);

   p_commit_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && hit && reg_wdata[15]) |=>
         (!hit || (reg_rdata[4 +: FPRI_W] == $past(reg_wdata[4 +: FPRI_W])
                   && reg_rdata[0 +: QPRI_W] == $past(reg_wdata[0 +: QPRI_W]))));

   p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && hit && reg_wdata[15]) |=> $stable(use_ip_fpri));

   p_flag_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && hit && reg_wdata[15]) |=> use_ip_fpri == $past(reg_wdata[14]));

   p_lookup_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && lk_dscp == ptr) |->
         (lk_qpri == reg_rdata[0 +: QPRI_W] && lk_fpri == reg_rdata[4 +: FPRI_W]));
endmodule

bind dscp_prio_map dpm_checker #(
   .ADDR_W(ADDR_W), .MAP_ADDR(MAP_ADDR),
   .DSCP_W(DSCP_W), .QPRI_W(QPRI_W), .FPRI_W(FPRI_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
   .lk_dscp(lk_dscp), .lk_qpri(lk_qpri), .lk_fpri(lk_fpri),
   .use_ip_fpri(use_ip_fpri), .ptr(ptr_q)
);

// File: tb/dscp_prio_map_tb_top.sv
module dscp_prio_map_tb_top;
   localparam logic [4:0] MAP_A   = 5'd25;
   localparam logic [4:0] OTHER_A = 5'd24;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [4:0]  reg_addr;
   logic [15:0] reg_wdata;
   logic        reg_we;
   logic [15:0] reg_rdata;
   logic [5:0]  lk_dscp;
   logic [1:0]  lk_qpri;
   logic [2:0]  lk_fpri;
   logic        use_ip_fpri;

   int n_chk = 0;
   int n_fail = 0;
   logic done = 1'b0;

   always #4 clk = ~clk;

   dscp_prio_map dut_i (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
      .lk_dscp(lk_dscp), .lk_qpri(lk_qpri), .lk_fpri(lk_fpri), .use_ip_fpri(use_ip_fpri)
   );

   typedef struct packed {
      logic [15:0] wdata;
      logic [15:0] exp;
   } vec_t;

   // Register writes and the read-back expected after each (R2, R3, R4, R5).
   localparam vec_t VECS [8] = '{
      '{16'h2100, 16'h2142},  // R2 pointer to 0x21, default q2 f4
      '{16'h4A77, 16'h0A10},  // R2 junk fields and flag bit ignored without commit
      '{16'hCA63, 16'h4A63},  // R4 commit 0x0A f6 q3, R5 flag set
      '{16'h3F00, 16'h7F73},  // R2 pointer only, flag kept, default q3 f7
      '{16'hBF00, 16'h3F00},  // R4 commit 0x3F f0 q0, R5 flag cleared
      '{16'h0A00, 16'h0A63},  // R3 entry 0x0A kept its committed value
      '{16'h90AD, 16'h1021},  // R4 bits 7,3,2 ignored, commit 0x10 f2 q1
      '{16'h0000, 16'h0000}   // R3 back to entry 0
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [4:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = MAP_A;
   endtask

   initial begin
      #1600000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; reg_addr = MAP_A; reg_wdata = '0; reg_we = 1'b0; lk_dscp = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      check("R1 rdata", {16'h0, reg_rdata}, 32'h0);
      check("R1 flag", {31'h0, use_ip_fpri}, 32'h0);
      for (int d = 0; d < 64; d++) begin
         lk_dscp = 6'(d);
         #1;
         check("R1 lk_qpri", {30'h0, lk_qpri}, 32'(d >> 4));
         check("R1 lk_fpri", {29'h0, lk_fpri}, 32'(d >> 3));
      end

      // Vector walk: R2 R3 R4 R5
      for (int i = 0; i < 8; i++) begin
         reg_write(MAP_A, VECS[i].wdata);
         check("R2/R3/R4/R5 vector", {16'h0, reg_rdata}, {16'h0, VECS[i].exp});
      end

      // R2: entry 0x21 untouched by pointer writes, seen on lookup
      lk_dscp = 6'h21; #1;
      check("R2 lk_qpri 0x21", {30'h0, lk_qpri}, 32'd2);

      // R7: other address writes change nothing and read as 0
      reg_write(OTHER_A, 16'hFFFF);
      reg_addr = OTHER_A; #1;
      check("R7 rdata other", {16'h0, reg_rdata}, 32'h0);
      reg_addr = MAP_A; #1;
      check("R7 rdata map", {16'h0, reg_rdata}, 32'h0);
      check("R7 flag", {31'h0, use_ip_fpri}, 32'h0);
      lk_dscp = 6'h3F; #1;
      check("R7 entry 0x3F", {29'h0, lk_fpri, lk_qpri}, 32'h0);

      // R6: lookup and commit collide on entry 0x05
      @(negedge clk);
      lk_dscp = 6'h05; reg_addr = MAP_A; reg_wdata = 16'h8552; reg_we = 1'b1;
      #1;
      check("R6 old qpri", {30'h0, lk_qpri}, 32'd0);
      check("R6 old fpri", {29'h0, lk_fpri}, 32'd0);
      @(negedge clk);
      reg_we = 1'b0;
      #1;
      check("R6 new qpri", {30'h0, lk_qpri}, 32'd2);
      check("R6 new fpri", {29'h0, lk_fpri}, 32'd5);
      check("R4 ptr after commit", {16'h0, reg_rdata}, 32'h0552);

      // R5: flag set by commit, kept over a pointer write with bit 14 clear
      reg_write(MAP_A, 16'hC000 | 16'h0102);
      check("R5 flag set", {31'h0, use_ip_fpri}, 32'h1);
      reg_write(MAP_A, 16'h2000);
      check("R5 flag kept", {31'h0, use_ip_fpri}, 32'h1);
      check("R3 flag readback", {16'h0, reg_rdata}, 32'h6042);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule